// File: doc/BRIEF.md
# Serial Shift Register and Event Counter

This block holds one small register that works in one of two modes, picked by two static mode inputs. In shift mode the register moves one place toward its top bit on every instruction cycle, takes a fresh bit from the serial input into its bottom bit, and can present its top bit on the serial data output. In counter mode the same register counts down once for each qualified high-to-low pulse on the serial input. A qualified pulse is one that stays low for at least two instruction cycles.

Software reaches the register through an exchange command. The command writes an accumulator value into the register and returns the previous contents. In the same cycle it copies the carry bit into a clock-gate latch. In counter mode the clock output shows that latch as a level. In shift mode it shows the latch gated with the instruction clock. After reset the latch is set, so with the mode inputs at zero the clock output gives one pulse per instruction cycle. To keep a serial stream running without gaps, the exchange must be issued every four instruction cycles.

Top module: `sio_shift_count`

## Requirements
- R1: In shift mode (`enCount`=0), every cycle without an exchange shifts the register toward its top bit and places the synchronised serial input in bit 0.
- R2: In shift mode, `soOut` equals register bit 3 when `enSerOut`=1 and is 0 when `enSerOut`=0; shifting continues in both cases.
- R3: In counter mode (`enCount`=1), the register decrements by one for each high-to-low pulse of `serIn` that stays low for at least two cycles. A pulse that is low for only one cycle does not change the count.
- R4: In counter mode, a decrement from 0 gives 15.
- R5: In counter mode, `soOut` equals `enSerOut`.
- R6: `skOut` equals the clock-gate latch in counter mode. In shift mode it equals the latch ANDed with `clk`.
- R7: An exchange (`xchgEn`=1 at a clock edge) loads `xchgAcc` into the register, presents the previous register value on `xchgRet` from that edge on, and copies `xchgCarry` into the clock-gate latch.
- R8: If an exchange falls in the same cycle as a shift or a qualified decrement, the exchange wins and the shift or decrement is dropped.
- R9: While `rstN` is low, the register and `xchgRet` are cleared and the clock-gate latch is set.
- R10: `serIn` passes through a two-stage synchroniser. A level applied just before an exchange edge E first enters bit 0 at edge E+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serIn | input | 1 | Serial data in, or pulse input in counter mode |
| enCount | input | 1 | Mode select: 1 = down-counter, 0 = shift register |
| enSerOut | input | 1 | Serial output enable in shift mode; output level in counter mode |
| xchgEn | input | 1 | Exchange command |
| xchgAcc | input | 4 | Accumulator value written by the exchange |
| xchgCarry | input | 1 | Carry bit copied into the clock-gate latch |
| soOut | output | 1 | Serial data output |
| skOut | output | 1 | Clock output |
| xchgRet | output | 4 | Register value returned by the last exchange |

## Verification
The assertions assume that `enCount` is held steady around the edges they check, because the mode pins are written rarely and not during a transfer. The bench changes mode only while no pulse or shift result is pending, and lets the synchroniser settle before each measurement. Pulse stimulus is always preceded by a high level so the edge qualifier is armed. For the priority check, a single exchange is lined up with the exact edge on which a qualified decrement would land.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // strobes from control to datapath; at most one of them is active per cycle
  typedef struct packed {
    logic load;   // exchange: take accumulator, return old value
    logic shift;  // shift mode step
    logic dec;    // counter mode qualified pulse
  } sioStrobe_t;
endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serIn,
  input  logic       enCount,
  input  logic       xchgEn,
  output logic       syncBit,
  output sioStrobe_t stb
);
  localparam int LOW_W = $clog2(MIN_LOW + 1);

  logic [SYNC_STAGES-1:0] syncChain;

  // synchroniser stages
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= serIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[i] <= 1'b0;
          else       syncChain[i] <= syncChain[i-1];
      end
    end
  endgenerate

  assign syncBit = syncChain[SYNC_STAGES-1];

  // pulse qualifier: needs a high level, then MIN_LOW consecutive lows
  logic [LOW_W-1:0] lowRun;
  logic             armed;
  logic             fire;

  assign fire = armed && !syncBit && (lowRun == LOW_W'(MIN_LOW - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun <= '0;
      armed  <= 1'b0;
    end else if (syncBit) begin
      lowRun <= '0;
      armed  <= 1'b1;
    end else begin
      if (lowRun < LOW_W'(MIN_LOW)) lowRun <= lowRun + 1'b1;
      if (fire) armed <= 1'b0;
    end
  end

  // exchange has priority over shift and decrement
  always_comb begin
    stb.load  = xchgEn;
    stb.shift = !enCount && !xchgEn;
    stb.dec   = enCount && fire && !xchgEn;
  end
endmodule

// File: rtl/sio_datapath.sv
module sio_datapath
  import sio_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  sioStrobe_t       stb,
  input  logic             serBit,
  input  logic [WIDTH-1:0] xchgAcc,
  input  logic             xchgCarry,
  input  logic             enCount,
  input  logic             enSerOut,
  output logic [WIDTH-1:0] regVal,
  output logic [WIDTH-1:0] xchgRet,
  output logic             gateBit,
  output logic             soOut,
  output logic             skOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regVal  <= '0;
      xchgRet <= '0;
      gateBit <= 1'b1;
    end else begin
      if (stb.load) begin
        regVal  <= xchgAcc;
        xchgRet <= regVal;
        gateBit <= xchgCarry;
      end else if (stb.shift) begin
        regVal  <= {regVal[WIDTH-2:0], serBit};
      end else if (stb.dec) begin
        regVal  <= regVal - 1'b1;
      end
    end
  end

  always_comb begin
    if (enCount) begin
      soOut = enSerOut;
      skOut = gateBit;
    end else begin
      soOut = enSerOut & regVal[WIDTH-1];
      skOut = gateBit & clk;
    end
  end
endmodule

// File: rtl/sio_shift_count.sv
module sio_shift_count
  import sio_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             enCount,
  input  logic             enSerOut,
  input  logic             xchgEn,
  input  logic [WIDTH-1:0] xchgAcc,
  input  logic             xchgCarry,
  output logic             soOut,
  output logic             skOut,
  output logic [WIDTH-1:0] xchgRet
);
  sioStrobe_t       stb;
  logic             syncBit;
  logic [WIDTH-1:0] regVal;
  logic             gateBit;

  sio_ctrl #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW(MIN_LOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .serIn(serIn), .enCount(enCount),
    .xchgEn(xchgEn), .syncBit(syncBit), .stb(stb)
  );

  sio_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .serBit(syncBit),
    .xchgAcc(xchgAcc), .xchgCarry(xchgCarry), .enCount(enCount),
    .enSerOut(enSerOut), .regVal(regVal), .xchgRet(xchgRet),
    .gateBit(gateBit), .soOut(soOut), .skOut(skOut)
  );
endmodule

// File: rtl/sio_shift_count_chk.sv
module sio_shift_count_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             enCount,
  input logic             xchgEn,
  input logic [WIDTH-1:0] xchgAcc,
  input logic             xchgCarry,
  input logic [WIDTH-1:0] xchgRet,
  input logic [WIDTH-1:0] regVal,
  input logic             syncBit,
  input logic             gateBit,
  input logic             shiftStb,
  input logic             decStb
);
  // R1: shift step takes the synchronised bit
  p_shift_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!enCount && !xchgEn) |=> regVal == {$past(regVal[WIDTH-2:0]), $past(syncBit)});

  // R3: counter mode never moves by more than one step down
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enCount && !xchgEn) |=> (regVal == $past(regVal)) ||
                             (regVal == WIDTH'($past(regVal) - 1'b1)));

  // R4: wrap from zero
  p_count_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (decStb && regVal == '0) |=> regVal == '1);

  // R7: exchange swaps and copies carry
  p_exchange_r7: assert property (@(posedge clk) disable iff (!rstN)
    xchgEn |=> (regVal == $past(xchgAcc)) && (xchgRet == $past(regVal)) &&
               (gateBit == $past(xchgCarry)));

  // R8: exchange blocks both other strobes
  p_xchg_priority_r8: assert property (@(posedge clk) disable iff (!rstN)
    xchgEn |-> !shiftStb && !decStb);
endmodule

bind sio_shift_count sio_shift_count_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .enCount(enCount), .xchgEn(xchgEn),
  .xchgAcc(xchgAcc), .xchgCarry(xchgCarry), .xchgRet(xchgRet),
  .regVal(regVal), .syncBit(syncBit), .gateBit(gateBit),
  .shiftStb(stb.shift), .decStb(stb.dec)
);

// File: tb/sio_shift_count_tb.sv
module sio_shift_count_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b1;
  logic enCount = 1'b0;
  logic enSerOut = 1'b0;
  logic xchgEn = 1'b0;
  logic [3:0] xchgAcc = '0;
  logic xchgCarry = 1'b0;
  logic soOut, skOut;
  logic [3:0] xchgRet;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sio_shift_count u_dut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .enCount(enCount),
    .enSerOut(enSerOut), .xchgEn(xchgEn), .xchgAcc(xchgAcc),
    .xchgCarry(xchgCarry), .soOut(soOut), .skOut(skOut), .xchgRet(xchgRet)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic xchg(input logic [3:0] acc, input logic cy);
    xchgAcc = acc; xchgCarry = cy; xchgEn = 1'b1;
    @(posedge clk); #1;
    xchgEn = 1'b0;
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    #3;
    chk("R9 ret", xchgRet, 0);
    chk("R9 so", soOut, 0);
    #4; // clk high phase
    chk("R9 sk high", skOut, 1);
    @(negedge clk); #1;
    chk("R9 sk low", skOut, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    idle(2);
    xchg(4'd0, 1'b1);
    chk("R9 reg cleared", xchgRet, 0);

    // R1/R2: shift sweep
    for (int b = 0; b < 2; b++) begin
      serIn = b[0];
      idle(3);
      for (int v = 0; v < 16; v++) begin
        for (int k = 1; k <= 4; k++) begin
          enSerOut = v[0];
          xchg(4'(v), 1'b1);
          chk("R2 so after load", soOut, v[0] & v[3]);
          idle(k);
          xchg(4'd0, 1'b1);
          chk("R1 shift result", xchgRet,
              ((v << k) | (b ? ((1 << k) - 1) : 0)) & 15);
        end
      end
    end

    // R6 shift mode gating, R7 carry copy
    for (int c = 0; c < 2; c++) begin
      xchg(4'd3, c[0]);
      chk("R7 ret", xchgRet, 0);
      chk("R6 shift sk clk-high", skOut, c);
      @(negedge clk); #1;
      chk("R6 shift sk clk-low", skOut, 0);
      @(posedge clk); #1;
      xchg(4'd0, 1'b1);
    end

    // R10: two-stage latency
    for (int k = 1; k <= 3; k++) begin
      serIn = 1'b0;
      idle(4);
      serIn = 1'b1;
      xchg(4'd0, 1'b1);
      idle(k);
      xchg(4'd0, 1'b1);
      chk("R10 latency", xchgRet, (1 << (k - 1)) - 1);
    end

    // counter mode
    serIn = 1'b1;
    enCount = 1'b1;
    idle(4);
    for (int e = 0; e < 2; e++) begin
      enSerOut = e[0];
      #1;
      chk("R5 so", soOut, e);
    end
    for (int c = 0; c < 2; c++) begin
      xchg(4'd0, c[0]);
      chk("R6 count sk high", skOut, c);
      @(negedge clk); #1;
      chk("R6 count sk low", skOut, c);
      @(posedge clk); #1;
    end

    // R3/R4: pulses widths 1,2,3 -> two decrements
    for (int v = 0; v < 16; v++) begin
      xchg(4'(v), 1'b1);
      for (int w = 1; w <= 3; w++) begin
        serIn = 1'b0; idle(w);
        serIn = 1'b1; idle(4);
      end
      xchg(4'd0, 1'b1);
      chk(v < 2 ? "R4 wrap" : "R3 count", xchgRet, (v + 14) & 15);
    end
    // R3: single-cycle pulse ignored alone
    xchg(4'd6, 1'b1);
    serIn = 1'b0; idle(1); serIn = 1'b1; idle(5);
    xchg(4'd0, 1'b1);
    chk("R3 short pulse ignored", xchgRet, 6);
    // R4: single pulse from zero
    xchg(4'd0, 1'b1);
    serIn = 1'b0; idle(3); serIn = 1'b1; idle(4);
    xchg(4'd0, 1'b1);
    chk("R4 zero wraps", xchgRet, 15);

    // R8: exchange on the decrement edge drops the decrement
    xchg(4'd9, 1'b1);
    idle(3);
    serIn = 1'b0;
    idle(3);
    xchg(4'd7, 1'b1);
    serIn = 1'b1;
    idle(5);
    xchg(4'd0, 1'b1);
    chk("R8 priority", xchgRet, 7);
    // same timing without exchange: decrement happens
    xchg(4'd9, 1'b1);
    idle(3);
    serIn = 1'b0;
    idle(4);
    serIn = 1'b1;
    idle(4);
    xchg(4'd0, 1'b1);
    chk("R3 decrement timing", xchgRet, 8);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule